// File: doc/BRIEF.md
# Sequential Read-Ahead Buffer

This block sits on the read path between a processor and a slow main memory. It keeps a single window of up to eight consecutive words. While the processor is idle or hitting in the window, the block keeps fetching the next sequential word from main memory until the window is full. The window is a circular store with one valid flag per slot, so the store never has to shift.

Every processor read is compared with the addresses the window covers. On a hit, the word comes from the window one clock later. The entries below the hit address are released so that read-ahead can refill them. On a miss, the processor waits for a direct read of main memory. Any read-ahead fetch still in flight is allowed to finish first, and its data is dropped. The window is then restarted at the missed address, and that word becomes its first entry. Read-ahead resumes at the next address. Hit and miss pulses and two running counters make the behaviour observable.

Top module: `prefetch_rd_cache`

## Requirements
- R1: After reset, cpu_ready is 1, cpu_rvalid, mem_req, hit_pulse and miss_pulse are 0, and both counters are 0. Read-ahead then starts at address 0.
- R2: A request to an address held in the window is a hit. One clock after the request, cpu_rvalid and hit_pulse are 1 and cpu_rdata is the memory word at that address.
- R3: A request to an address not held in the window is a miss. One clock after the request, miss_pulse is 1 and cpu_ready is 0. A main-memory read of that address follows, and cpu_rvalid with that word comes one clock after mem_rvalid.
- R4: After a miss, the window restarts at the missed address and holds that word, so an immediate repeat read hits. Read-ahead continues at the missed address plus one, plus two, and so on.
- R5: At most one main-memory read is outstanding. mem_req is never asserted before mem_rvalid has returned the previous read.
- R6: The window holds at most 8 words, counted from its oldest valid entry. Once 8 are held, no read-ahead request is issued.
- R7: A hit at offset k from the oldest entry releases the k older entries. Read-ahead then issues exactly k further sequential reads, and a later read of a released address misses.
- R8: A read-ahead fetch in flight when a miss arrives completes before the miss read is issued. Its data is not kept: a later read of that address misses.
- R9: hit_count and miss_count each increase by one per hit_pulse or miss_pulse.
- R10: hit_pulse and miss_pulse are never 1 together. Each accepted request yields exactly one cpu_rvalid.
- R11: A cpu_req while cpu_ready is 0 is ignored. It causes no memory read, no pulse and no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor read request, one cycle |
| cpu_addr | input | AW | Processor word address |
| cpu_ready | output | 1 | Block can accept a request |
| cpu_rvalid | output | 1 | Read data valid, one cycle |
| cpu_rdata | output | DW | Read data |
| mem_req | output | 1 | Main-memory read request, one cycle |
| mem_addr | output | AW | Main-memory word address |
| mem_rvalid | input | 1 | Main-memory data valid |
| mem_rdata | input | DW | Main-memory data |
| hit_pulse | output | 1 | One-cycle hit indication |
| miss_pulse | output | 1 | One-cycle miss indication |
| hit_count | output | CW | Running hit count |
| miss_count | output | CW | Running miss count |

## Verification
The bench fills the window and then hits at offsets 0, 3 and 7. It counts the read-ahead requests each hit releases: a design that freed the wrong number of slots would over-fetch or stall early. It then reads a just-released address, which must miss; a design that kept freed entries valid would return it as a hit. It raises the memory latency so that a read-ahead fetch is in flight when a miss arrives. The memory request order must show the miss read only after that fetch, and the address of that fetch must later miss, which catches a design that let the stale word into the restarted window. A request poked while the block is busy must leave no trace in the memory log or the counters.

// File: rtl/prefetch_rd_cache.sv
module prefetch_rd_cache #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  parameter int CW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic [AW-1:0] cpu_addr,
  output logic          cpu_ready,
  output logic          cpu_rvalid,
  output logic [DW-1:0] cpu_rdata,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  output logic          hit_pulse,
  output logic          miss_pulse,
  output logic [CW-1:0] hit_count,
  output logic [CW-1:0] miss_count
);
  localparam int PW = $clog2(DEPTH);

  logic [DW-1:0]    store [DEPTH];
  logic [DEPTH-1:0] vld, vld_n;
  logic [PW-1:0]    head;
  logic [PW:0]      fill;
  logic [AW-1:0]    base, miss_addr;
  logic             pf_out, miss_pend, miss_out;

  wire [AW-1:0] off      = cpu_addr - base;
  wire [PW-1:0] slot     = head + off[PW-1:0];
  wire          in_rng   = off < AW'(DEPTH);
  assign cpu_ready       = !miss_pend && !miss_out;
  wire          take     = cpu_req && cpu_ready;
  wire          hit      = take && in_rng && vld[slot];
  wire          miss     = take && !hit;
  wire          full     = fill == (PW+1)'(DEPTH);
  wire          pf_ret   = pf_out && mem_rvalid;
  wire          pf_keep  = pf_ret && !miss_pend && !miss;
  wire          miss_ret = miss_out && mem_rvalid;
  wire [PW-1:0] wr_slot  = head + fill[PW-1:0];
  wire          issue_pf = !pf_out && !miss_pend && !miss_out && !full && !miss;
  wire          issue_ms = miss_pend && !pf_out;
  wire [PW:0]   drop     = hit ? {1'b0, off[PW-1:0]} : '0;

  always_comb begin
    vld_n = vld;
    for (int i = 0; i < DEPTH; i++) begin
      logic [PW-1:0] rel;
      rel = PW'(i) - head;
      if (hit && ({1'b0, rel} < drop)) vld_n[i] = 1'b0;
    end
    if (pf_keep) vld_n[wr_slot] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (miss_ret)     store[0]       <= mem_rdata;
    else if (pf_keep) store[wr_slot] <= mem_rdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0; fill <= '0; head <= '0; base <= '0; miss_addr <= '0;
      pf_out <= 1'b0; miss_pend <= 1'b0; miss_out <= 1'b0;
      cpu_rvalid <= 1'b0; cpu_rdata <= '0; mem_req <= 1'b0; mem_addr <= '0;
      hit_pulse <= 1'b0; miss_pulse <= 1'b0; hit_count <= '0; miss_count <= '0;
    end else begin
      cpu_rvalid <= 1'b0;
      mem_req    <= 1'b0;
      hit_pulse  <= hit;
      miss_pulse <= miss;
      vld  <= vld_n;
      fill <= fill - drop + {{PW{1'b0}}, pf_keep};
      if (hit) begin
        cpu_rdata  <= store[slot];
        cpu_rvalid <= 1'b1;
        hit_count  <= hit_count + 1'b1;
        head       <= slot;
        base       <= cpu_addr;
      end
      if (miss) begin
        miss_count <= miss_count + 1'b1;
        miss_pend  <= 1'b1;
        miss_addr  <= cpu_addr;
      end
      if (pf_ret) pf_out <= 1'b0;
      if (issue_pf) begin
        mem_req  <= 1'b1;
        mem_addr <= base + AW'(fill);
        pf_out   <= 1'b1;
      end
      if (issue_ms) begin
        mem_req   <= 1'b1;
        mem_addr  <= miss_addr;
        miss_out  <= 1'b1;
        miss_pend <= 1'b0;
      end
      if (miss_ret) begin
        cpu_rdata  <= mem_rdata;
        cpu_rvalid <= 1'b1;
        miss_out   <= 1'b0;
        head       <= '0;
        base       <= miss_addr;
        vld        <= DEPTH'(1);
        fill       <= (PW+1)'(1);
      end
    end
  end

  p_hit_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_pulse |-> cpu_rvalid);
  p_miss_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    miss_pulse |-> !cpu_ready);
  p_one_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  p_full_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !miss_pend) |=> !mem_req);
  p_valid_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(vld) == 32'(fill));
  p_drain_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    miss_out |-> !pf_out);
  p_hit_cnt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hit_pulse |-> hit_count == $past(hit_count) + 1'b1);
  p_miss_cnt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    miss_pulse |-> miss_count == $past(miss_count) + 1'b1);
  p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_pulse && miss_pulse));
endmodule

// File: tb/sim_prefetch_rd_cache.sv
module sim_prefetch_rd_cache;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cpu_req = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_ready, cpu_rvalid, mem_req, hit_pulse, miss_pulse;
  logic [31:0] cpu_rdata, mem_rdata = '0;
  logic [15:0] mem_addr, hit_count, miss_count;
  logic        mem_rvalid = 1'b0;

  int errors = 0, checks = 0, lat = 3;
  bit fin = 1'b0;
  logic [31:0] exp_q[$];
  string       req_q[$];
  logic [15:0] mlog[$];
  logic        mbusy = 1'b0;
  int          mcnt = 0;
  logic [15:0] maddr = '0;

  always #2.5 clk = ~clk;

  prefetch_rd_cache u0 (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
    .cpu_ready(cpu_ready), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .hit_pulse(hit_pulse), .miss_pulse(miss_pulse),
    .hit_count(hit_count), .miss_count(miss_count));

  function automatic logic [31:0] word_of(input logic [15:0] a);
    return {~a, a};
  endfunction

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // memory model, one read at a time (R5)
  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (mbusy) begin
      if (mcnt <= 1) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= word_of(maddr);
        mbusy      <= 1'b0;
      end else mcnt <= mcnt - 1;
    end
    if (rst_n && mem_req) begin
      chk(!mbusy, "R5 overlap", 32'(mbusy), 0);
      mbusy <= 1'b1;
      mcnt  <= lat;
      maddr <= mem_addr;
      mlog.push_back(mem_addr);
    end
  end

  // monitor: scoreboard pop on each response (R10)
  always @(negedge clk) begin
    if (rst_n) begin
      if (hit_pulse && miss_pulse) chk(0, "R10 both pulses", 1, 0);
      if (cpu_rvalid) begin
        if (exp_q.size() == 0) chk(0, "R10/R11 unexpected rvalid", 1, 0);
        else begin
          logic [31:0] e;
          string r;
          e = exp_q.pop_front();
          r = req_q.pop_front();
          chk(cpu_rdata == e, r, cpu_rdata, e);
        end
      end
    end
  end

  task automatic rd(input logic [15:0] a, input bit exp_hit, input string r, input bit poke);
    int t;
    @(negedge clk);
    chk(cpu_ready == 1'b1, {r, " ready"}, 32'(cpu_ready), 1);
    exp_q.push_back(word_of(a));
    req_q.push_back({r, " data"});
    cpu_req = 1'b1; cpu_addr = a;
    @(negedge clk);
    cpu_req = 1'b0;
    chk(hit_pulse == exp_hit, {r, " hit_pulse"}, 32'(hit_pulse), 32'(exp_hit));
    chk(miss_pulse == !exp_hit, {r, " miss_pulse"}, 32'(miss_pulse), 32'(!exp_hit));
    if (!exp_hit) chk(cpu_ready == 1'b0, "R3 busy after miss", 32'(cpu_ready), 0);
    if (poke) begin
      cpu_req = 1'b1; cpu_addr = 16'h0333;  // R11 ignored request
      @(negedge clk);
      cpu_req = 1'b0;
    end
    t = 0;
    while (!cpu_rvalid && t < 300) begin @(negedge clk); t++; end
    chk(t < 300, {r, " response timeout"}, 32'(t), 0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_seq(input int from, input logic [15:0] a0, input int n, input string r);
    for (int i = 0; i < n; i++) begin
      logic [15:0] got;
      got = (from + i < mlog.size()) ? mlog[from + i] : 16'hxxxx;
      chk(got === a0 + 16'(i), r, 32'(got), 32'(a0 + 16'(i)));
    end
  endtask

  initial begin
    int m;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(cpu_rvalid == 0 && mem_req == 0, "R1 outputs idle", {cpu_rvalid, mem_req}, 0);
    chk(hit_count == 0 && miss_count == 0, "R1 counters", {hit_count, miss_count}, 0);
    chk(cpu_ready == 1 && hit_pulse == 0 && miss_pulse == 0, "R1 ready/pulses",
        {cpu_ready, hit_pulse, miss_pulse}, 32'b100);
    rst_n = 1'b1;
    idle(80);
    // R1 + R6: read-ahead from 0, stops at 8 words
    chk(mlog.size() == 8, "R6 window limit", mlog.size(), 8);
    chk_seq(0, 16'h0000, 8, "R1 first read-ahead order");
    // R2 hit at offset 3, R7 three refills
    m = mlog.size();
    rd(16'h0003, 1, "R2 hit offset 3", 0);
    idle(40);
    chk(mlog.size() == m + 3, "R7 refill count after offset 3", mlog.size() - m, 3);
    chk_seq(m, 16'h0008, 3, "R7 refill addresses");
    m = mlog.size();
    rd(16'h000A, 1, "R2 hit offset 7", 0);
    idle(60);
    chk(mlog.size() == m + 7, "R7 refill count after offset 7", mlog.size() - m, 7);
    // R7 released address misses, R3 miss path, R4 restart
    m = mlog.size();
    rd(16'h0005, 0, "R7 released address miss", 0);
    rd(16'h0005, 1, "R4 repeat after miss hits", 0);
    idle(60);
    chk(mlog.size() == m + 8, "R4/R6 miss plus seven", mlog.size() - m, 8);
    chk_seq(m, 16'h0005, 8, "R4 read-ahead after miss");
    rd(16'h000C, 1, "R2 hit at last slot", 0);
    idle(60);
    rd(16'h0013, 1, "R7 hit after full refill", 0);
    idle(60);
    // R8 in-flight read-ahead at miss, R11 poke while busy
    lat = 10;
    m = mlog.size();
    rd(16'h0F00, 0, "R3 far miss", 0);
    rd(16'h0200, 0, "R8 miss with fetch in flight", 1);
    chk(mlog.size() >= m + 3, "R8 request count", mlog.size() - m, 3);
    chk_seq(m, 16'h0F00, 2, "R8 in-flight fetch");
    chk_seq(m + 2, 16'h0200, 1, "R8 miss read after drain");
    idle(150);
    for (int i = m; i < mlog.size(); i++)
      chk(mlog[i] != 16'h0333, "R11 poke caused read", 32'(mlog[i]), 0);
    rd(16'h0F01, 0, "R8 discarded word misses", 0);
    idle(10);
    // R9 counters: 5 hits, 4 misses
    chk(hit_count == 5, "R9 hit_count", 32'(hit_count), 5);
    chk(miss_count == 4, "R9 miss_count", 32'(miss_count), 4);
    chk(exp_q.size() == 0, "R10 missing responses", exp_q.size(), 0);
    if (!fin) begin
      fin = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      fin = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule